// File: doc/BRIEF.md
# I2C Slave Address-Match Interrupt Unit

This block watches an I2C bus in slave mode through two pre-synchronized, oversampled inputs (SCL and SDA). It recognises start and stop conditions, counts the serial clocks of each byte, and shifts in the first byte after every start. That byte is compared with a programmable local address. When it matches, or when it carries a reserved extension code, the block raises a one-cycle interrupt request.

The interrupt can be placed on the falling edge of the 8th clock or on the falling edge of the 9th (acknowledge) clock. A stop condition can also raise the interrupt when that option is enabled. Once the block has been addressed, each later data byte of the same transfer raises the interrupt at the same chosen edge. After an address mismatch the block stays silent until the next start condition.

Software writes the local address and two control bits through a simple write port. The local address cannot be changed while a transfer is in progress.

Top module: `i2c_addr_irq`

## Requirements
- R1: Reset clears the local address register to 0x00. Bit 0 of that register always reads 0, so writing 0xFF with `wr_sel`=0 reads back 0xFE on `own_addr_o`.
- R2: A write to the local address register (`wr_sel`=0) is ignored while `start_seen_o` is 1. The same write is accepted once `start_seen_o` is 0 again.
- R3: `start_seen_o` is set by a start condition, which is SDA falling while SCL is high. It is cleared by a stop condition, which is SDA rising while SCL is high.
- R4: The first byte after a start is received MSB first. If its bits 7:1 equal bits 7:1 of the local address, the interrupt is raised. Bit 0 of that byte is reported on `rw_dir_o`.
- R5: If the first byte has an upper nibble of 0000 or 1111, it is an extension code. It sets `ext_code_o` and raises the interrupt whatever the local address is. `ext_code_o` is cleared by the next start.
- R6: Control bit 0 (`wr_sel`=1, `wr_data[0]`) selects the interrupt edge. At 0, the interrupt follows the falling edge of the 8th SCL clock of the byte. At 1, it follows the falling edge of the 9th clock, and nothing is raised at the 8th.
- R7: Control bit 1 (`wr_sel`=1, `wr_data[1]`) enables the stop interrupt. When it is 1, a stop condition raises the interrupt. When it is 0, a stop raises nothing.
- R8: After a first byte that neither matches nor is an extension code, no interrupt is raised for that byte or for any later byte until the next start. The only exception is the enabled stop interrupt.
- R9: After a match, every later byte of the same transfer raises the interrupt at the selected edge.
- R10: `irq_o` is a pulse exactly one clock cycle wide.
- R11: A start condition, including a repeated start in the middle of a byte, resets the bit counter. The byte that follows is then counted from its first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = local address, 1 = control |
| wr_data | input | 8 | Write data |
| irq_o | output | 1 | Interrupt request pulse |
| start_seen_o | output | 1 | Start detected, transfer in progress |
| ext_code_o | output | 1 | The last address byte was an extension code |
| rw_dir_o | output | 1 | Direction bit of the last address byte |
| own_addr_o | output | 8 | Local address register readback |

## Verification
The bench targets the following corner cases, and each one catches a specific fault:
- **Edge selection.** The interrupt count is sampled after the 8th falling edge and again after the 9th. An off-by-one bit counter, or a swapped edge select, fires one clock early or late.
- **Extension codes.** These are sent against a local address that does not match them. A design that relied on the address compare alone would stay silent.
- **Mismatch lockout.** A mismatching address is followed by a data byte. A design that forgot the mismatch would raise an interrupt on the data byte.
- **Repeated start.** A repeated start is issued after three bits. A counter that was not cleared would fire three clocks early.
- **Write lock.** The local address is rewritten in the middle of a transfer. A design that ignored the lock would change `own_addr_o`.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;

    // Bus events decoded from consecutive SCL/SDA samples.
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // Control register write targets.
    localparam logic SEL_ADDR = 1'b0;
    localparam logic SEL_CTRL = 1'b1;

endpackage

// File: rtl/i2c_addr_busevt.sv
module i2c_addr_busevt
    import i2c_addr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d.scl = scl_i;
        smp_d.sda = sda_i;
        evt_o.scl_rise = scl_i & ~smp_q.scl;
        evt_o.scl_fall = ~scl_i & smp_q.scl;
        evt_o.start    = scl_i & smp_q.scl & smp_q.sda & ~sda_i;
        evt_o.stop     = scl_i & smp_q.scl & ~smp_q.sda & sda_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            smp_q <= smp_d;
        end
    end
endmodule

// File: rtl/i2c_addr_cfg.sv
module i2c_addr_cfg
    import i2c_addr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lock,
    output logic [DATA_W-1:0] own_addr,
    output logic              nine_sel,
    output logic              stop_ie
);
    typedef struct packed {
        logic [DATA_W-1:0] addr;
        logic              nine;
        logic              sie;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && wr_sel == SEL_ADDR && !lock) begin
            cfg_d.addr = {wr_data[DATA_W-1:1], 1'b0};
        end
        if (wr_en && wr_sel == SEL_CTRL) begin
            cfg_d.nine = wr_data[0];
            cfg_d.sie  = wr_data[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign own_addr = cfg_q.addr;
    assign nine_sel = cfg_q.nine;
    assign stop_ie  = cfg_q.sie;
endmodule

// File: rtl/i2c_addr_rx.sv
module i2c_addr_rx
    import i2c_addr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic              sda_i,
    output logic [DATA_W-1:0] rx_byte,
    output logic              fall_data,
    output logic              fall_ack
);
    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ACK_CLK   = CNT_W'(DATA_W + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (evt.start || evt.stop) begin
            rx_d.cnt = '0;
        end else if (evt.scl_rise) begin
            if (rx_q.cnt < LAST_DATA) begin
                rx_d.shreg = {rx_q.shreg[DATA_W-2:0], sda_i};
            end
            if (rx_q.cnt < ACK_CLK) begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end else if (evt.scl_fall && rx_q.cnt == ACK_CLK) begin
            rx_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rx_byte   = rx_q.shreg;
    assign fall_data = evt.scl_fall && rx_q.cnt == LAST_DATA;
    assign fall_ack  = evt.scl_fall && rx_q.cnt == ACK_CLK;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_addr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-2:0] own_id,
    input  logic              fall_data,
    input  logic              fall_ack,
    input  logic              nine_sel,
    input  logic              stop_ie,
    output logic              irq,
    output logic              started,
    output logic              ext_code,
    output logic              rw_dir
);
    typedef struct packed {
        logic started;
        logic first;
        logic addressed;
        logic ext;
        logic rw;
        logic irq;
    } mt_t;

    mt_t mt_d, mt_q;
    logic id_hit, ext_now, sel_now;

    always_comb begin
        id_hit  = rx_byte[DATA_W-1:1] == own_id;
        ext_now = rx_byte[DATA_W-1 -: 4] == 4'b0000 ||
                  rx_byte[DATA_W-1 -: 4] == 4'b1111;
        sel_now = id_hit || ext_now;

        mt_d     = mt_q;
        mt_d.irq = 1'b0;
        if (evt.start) begin
            mt_d.started   = 1'b1;
            mt_d.first     = 1'b1;
            mt_d.addressed = 1'b0;
            mt_d.ext       = 1'b0;
        end else if (evt.stop) begin
            mt_d.started   = 1'b0;
            mt_d.first     = 1'b0;
            mt_d.addressed = 1'b0;
            mt_d.irq       = stop_ie;
        end else if (fall_data) begin
            if (mt_q.first) begin
                mt_d.addressed = sel_now;
                mt_d.ext       = ext_now;
                mt_d.rw        = rx_byte[0];
                mt_d.irq       = !nine_sel && sel_now;
            end else begin
                mt_d.irq       = !nine_sel && mt_q.addressed;
            end
        end else if (fall_ack) begin
            mt_d.first = 1'b0;
            mt_d.irq   = nine_sel && mt_q.addressed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mt_q <= '0;
        end else begin
            mt_q <= mt_d;
        end
    end

    assign irq      = mt_q.irq;
    assign started  = mt_q.started;
    assign ext_code = mt_q.ext;
    assign rw_dir   = mt_q.rw;
endmodule

// File: rtl/i2c_addr_irq.sv
module i2c_addr_irq
    import i2c_addr_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [ADDR_W:0]   wr_data,
    output logic              irq_o,
    output logic              start_seen_o,
    output logic              ext_code_o,
    output logic              rw_dir_o,
    output logic [ADDR_W:0]   own_addr_o
);
    localparam int DATA_W = ADDR_W + 1;

    bus_evt_t          evt_w;
    logic [DATA_W-1:0] own_addr_w;
    logic [DATA_W-1:0] rx_byte_w;
    logic              nine_sel_w, stop_ie_w;
    logic              fall_data_w, fall_ack_w;
    logic              started_w;

    i2c_addr_busevt u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt_w)
    );

    i2c_addr_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .lock     (started_w),
        .own_addr (own_addr_w),
        .nine_sel (nine_sel_w),
        .stop_ie  (stop_ie_w)
    );

    i2c_addr_rx #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt_w),
        .sda_i     (sda_i),
        .rx_byte   (rx_byte_w),
        .fall_data (fall_data_w),
        .fall_ack  (fall_ack_w)
    );

    i2c_addr_match #(.DATA_W(DATA_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt_w),
        .rx_byte   (rx_byte_w),
        .own_id    (own_addr_w[DATA_W-1:1]),
        .fall_data (fall_data_w),
        .fall_ack  (fall_ack_w),
        .nine_sel  (nine_sel_w),
        .stop_ie   (stop_ie_w),
        .irq       (irq_o),
        .started   (started_w),
        .ext_code  (ext_code_o),
        .rw_dir    (rw_dir_o)
    );

    assign start_seen_o = started_w;
    assign own_addr_o   = own_addr_w;
endmodule

// File: rtl/i2c_addr_irq_chk.sv
module i2c_addr_irq_chk #(
    parameter int ADDR_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_i,
    input logic            sda_i,
    input logic            irq_o,
    input logic            start_seen_o,
    input logic [ADDR_W:0] own_addr_o,
    input logic            stop_ie
);
    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R2
    addr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen_o |=> $stable(own_addr_o));

    // R3
    start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_seen_o) |-> ($past(scl_i) && !$past(sda_i)));

    // R3
    stop_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_seen_o) |-> ($past(scl_i) && $past(sda_i)));

    // R7
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !start_seen_o) |-> stop_ie);
endmodule

bind i2c_addr_irq i2c_addr_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .sda_i        (sda_i),
    .irq_o        (irq_o),
    .start_seen_o (start_seen_o),
    .own_addr_o   (own_addr_o),
    .stop_ie      (stop_ie_w)
);

// File: tb/sim_i2c_addr_irq.sv
module sim_i2c_addr_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       irq, start_seen, ext_code, rw_dir;
    logic [7:0] own_addr;

    int n_checks = 0, n_fail = 0, irq_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    i2c_addr_irq u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_o(irq), .start_seen_o(start_seen), .ext_code_o(ext_code),
        .rw_dir_o(rw_dir), .own_addr_o(own_addr)
    );

    always @(posedge clk) begin
        if (!rst_n) irq_cnt <= 0;
        else if (irq) irq_cnt <= irq_cnt + 1;
    end

    // {sva[6:0], byte[7:0], nine, irq_at8, irq_at9, ext, rw}
    localparam int NV = 9;
    localparam logic [19:0] VEC [NV] = '{
        {7'h3A, 8'h74, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {7'h3A, 8'h75, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {7'h3A, 8'h76, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {7'h3A, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {7'h3A, 8'hF1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        {7'h55, 8'hAB, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        {7'h55, 8'hAA, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {7'h7F, 8'hFE, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {7'h10, 8'h23, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        tick(1);
    endtask

    task automatic bus_start();
        sda = 1'b1; tick(2);
        scl = 1'b1; tick(4);
        sda = 1'b0; tick(4);
        scl = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        sda = 1'b0; tick(2);
        scl = 1'b1; tick(4);
        sda = 1'b1; tick(4);
    endtask

    task automatic send_bit(input logic b);
        sda = b;    tick(2);
        scl = 1'b1; tick(4);
        scl = 1'b0; tick(4);
    endtask

    task automatic send_bits8(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    initial begin
        int base;
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        chk(own_addr == 8'h00, "R1 reset addr", own_addr, 0);
        chk(start_seen == 1'b0, "R3 reset start_seen", start_seen, 0);
        chk(irq == 1'b0 && ext_code == 1'b0, "R10 reset irq/ext", irq, 0);

        // Vector table: R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            logic [6:0] sva; logic [7:0] by; logic nine, i8, i9, ex, rw;
            {sva, by, nine, i8, i9, ex, rw} = VEC[v];
            wr(1'b0, {sva, 1'b0});
            wr(1'b1, {7'b0, nine});
            base = irq_cnt;
            bus_start();
            send_bits8(by);
            chk(irq_cnt - base == int'(i8), "R6 irq after 8th fall", irq_cnt - base, i8);
            send_bit(1'b0);
            chk(irq_cnt - base == int'(i8) + int'(i9), "R4 irq after 9th fall",
                irq_cnt - base, i8 + i9);
            chk(ext_code == ex, "R5 ext flag", ext_code, ex);
            chk(rw_dir == rw, "R4 rw dir", rw_dir, rw);
            base = irq_cnt;
            bus_stop();
            chk(irq_cnt == base, "R7 no stop irq when disabled", irq_cnt - base, 0);
            chk(start_seen == 1'b0, "R3 stop clears start_seen", start_seen, 0);
        end

        // R1 bit 0 forced low
        wr(1'b0, 8'hFF);
        chk(own_addr == 8'hFE, "R1 lsb forced 0", own_addr, 8'hFE);

        // R2 / R3 write lock during transfer
        bus_start();
        chk(start_seen == 1'b1, "R3 start sets start_seen", start_seen, 1);
        wr(1'b0, 8'h10);
        chk(own_addr == 8'hFE, "R2 write ignored while started", own_addr, 8'hFE);
        bus_stop();
        wr(1'b0, 8'h20);
        chk(own_addr == 8'h20, "R2 write accepted after stop", own_addr, 8'h20);

        // R8 mismatch lockout, R7 stop irq enabled
        wr(1'b1, 8'h02);
        base = irq_cnt;
        bus_start();
        send_bits8(8'h44); send_bit(1'b0);
        send_bits8(8'h20); send_bit(1'b0);
        chk(irq_cnt == base, "R8 no irq after mismatch", irq_cnt - base, 0);
        bus_stop();
        chk(irq_cnt - base == 1, "R7 stop irq enabled", irq_cnt - base, 1);

        // R9 matched transfer: data byte also interrupts at the 8th fall
        wr(1'b1, 8'h00);
        base = irq_cnt;
        bus_start();
        send_bits8(8'h20); send_bit(1'b0);
        send_bits8(8'h5A);
        chk(irq_cnt - base == 2, "R9 data byte irq", irq_cnt - base, 2);
        send_bit(1'b0);
        chk(irq_cnt - base == 2, "R9 no extra irq at 9th", irq_cnt - base, 2);
        bus_stop();

        // R11 repeated start mid-byte restarts the count
        base = irq_cnt;
        bus_start();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        send_bits8(8'h21);
        chk(irq_cnt - base == 1, "R11 count after repeated start", irq_cnt - base, 1);
        chk(rw_dir == 1'b1, "R11 rw of restarted byte", rw_dir, 1);
        send_bit(1'b0);
        bus_stop();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule